// File: doc/BRIEF.md
# Packet Buffer Burst Copy Engine

This coprocessor moves a byte range from a packet's receive buffer into a transmit buffer that has already been allocated. The execution unit issues one command and then keeps running its own instructions while the engine copies. The command gives the source and destination buffer identifiers, a start address in each buffer, a byte count and the tag of the general register that will receive the outcome. When the engine finishes, it presents a one-cycle result with that tag and a signed status value. The register file uses this to mark the register ready.

The byte count can be any value from zero up to the buffer size. The engine reads one source byte per cycle. The source port returns each byte one cycle after the request, and the engine writes it straight to the destination port. If a range does not fit in its buffer, the command is refused with a negative status and nothing is written. A zero count succeeds at once. A command that arrives while a copy is running is turned away on the spot and is not held for later. The timeout that kills a runaway program has no effect on a copy that is already running. Such a kill only stops a command presented in the same cycle from starting.

Top module: `burst_copy_engine`

## Requirements
- R1: A command presented with `cmd_valid` while the engine is idle and `exec_kill` is low is accepted, with `cmd_refused` low. For every i below the count, the byte at source address `cmd_src_addr`+i of space `cmd_src_space` ends up at destination address `cmd_dst_addr`+i of space `cmd_dst_space`. No other destination byte is written.
- R2: Transfer runs at one byte per cycle. Source reads start in the cycle after the accepting edge. Each returned byte is written in the following cycle. For a count L ≥ 1, the result is valid in the cycle that begins L+1 clock edges after the accepting edge.
- R3: Any count from 1 up to the full buffer size is copied exactly, with no alignment or word-multiple restriction.
- R4: A zero count with in-range addresses produces a success result in the cycle right after the accepting edge and makes no writes.
- R5: If `cmd_src_addr`+count exceeds the source buffer size, or `cmd_dst_addr`+count exceeds the destination buffer size, the command is rejected. The result value is -1 (all ones), it is valid in the cycle after the accepting edge, and no destination byte is written.
- R6: A successful result carries the value `cmd_dst_space`+1 (always positive) as a handle, and `res_tag` equals the command's `cmd_tag`. The same holds for rejected commands' tags.
- R7: While `busy` is high, a presented command raises `cmd_refused` in the same cycle. It is dropped, not queued: it produces no result and no writes.
- R8: Raising `exec_kill` while a copy is running neither stops nor delays it. The copy completes with the normal timing, data and result.
- R9: A command presented in a cycle where `exec_kill` is high is refused and produces no result.
- R10: `res_valid` is a single-cycle pulse. `busy` is low in the result cycle, and `busy` falls only together with a result.
- R11: After reset `busy`, `res_valid`, `src_rd_en` and `dst_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_kill | input | 1 | Program execution timeout kill |
| cmd_valid | input | 1 | Command presented |
| cmd_src_space | input | SPACE_W | Source buffer identifier |
| cmd_src_addr | input | AW | Source start byte |
| cmd_len | input | AW+1 | Byte count |
| cmd_dst_space | input | SPACE_W | Destination buffer identifier |
| cmd_dst_addr | input | AW | Destination start byte |
| cmd_tag | input | TAG_W | Result register tag |
| cmd_refused | output | 1 | Command turned away this cycle |
| busy | output | 1 | Copy in progress |
| src_rd_en | output | 1 | Source byte read request |
| src_rd_space | output | SPACE_W | Source buffer of the read |
| src_rd_addr | output | AW | Source byte address |
| src_rd_data | input | 8 | Source byte, one cycle after the request |
| dst_wr_en | output | 1 | Destination byte write |
| dst_wr_space | output | SPACE_W | Destination buffer of the write |
| dst_wr_addr | output | AW | Destination byte address |
| dst_wr_data | output | 8 | Destination byte |
| res_valid | output | 1 | Result writeback pulse |
| res_tag | output | TAG_W | Register to make ready |
| res_value | output | RES_W | Signed status: handle or -1 |

## Verification
The bound properties check, on every cycle, these rules: every read is followed by a write, no access falls outside either buffer, writes happen only while busy, the result is a single pulse, busy never drops without a result, and a command refused during a kill yields no result. Whether the bytes are the right ones, whether latency matches the count, and the handle and reject values can only be shown by the bench. Its sweep over counts and buffer-edge offsets compares the whole destination image, and its scenarios overlap a copy with a second command or with a kill pulse.

// File: rtl/burst_copy_engine.sv
module burst_copy_engine #(
  parameter int SRC_BYTES = 64,
  parameter int DST_BYTES = 64,
  parameter int SPACE_W   = 3,
  parameter int TAG_W     = 6,
  parameter int RES_W     = 8,
  localparam int AW = $clog2(SRC_BYTES > DST_BYTES ? SRC_BYTES : DST_BYTES),
  localparam int LW = AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_kill,
  input  logic               cmd_valid,
  input  logic [SPACE_W-1:0] cmd_src_space,
  input  logic [AW-1:0]      cmd_src_addr,
  input  logic [LW-1:0]      cmd_len,
  input  logic [SPACE_W-1:0] cmd_dst_space,
  input  logic [AW-1:0]      cmd_dst_addr,
  input  logic [TAG_W-1:0]   cmd_tag,
  output logic               cmd_refused,
  output logic               busy,
  output logic               src_rd_en,
  output logic [SPACE_W-1:0] src_rd_space,
  output logic [AW-1:0]      src_rd_addr,
  input  logic [7:0]         src_rd_data,
  output logic               dst_wr_en,
  output logic [SPACE_W-1:0] dst_wr_space,
  output logic [AW-1:0]      dst_wr_addr,
  output logic [7:0]         dst_wr_data,
  output logic               res_valid,
  output logic [TAG_W-1:0]   res_tag,
  output logic [RES_W-1:0]   res_value
);
  localparam int SW = LW + 1;
  localparam logic [RES_W-1:0] REJECT = '1;

  logic               busy_q, wr_pend_q, res_valid_q;
  logic [LW-1:0]      left_q;
  logic [AW-1:0]      rd_addr_q, wr_addr_q;
  logic [SPACE_W-1:0] src_sp_q, dst_sp_q;
  logic [TAG_W-1:0]   tag_q, res_tag_q;
  logic [RES_W-1:0]   res_value_q;

  logic accept, src_fits, dst_fits, last_write;

  assign accept      = cmd_valid && !busy_q && !exec_kill;
  assign cmd_refused = cmd_valid && !accept;
  assign src_fits    = (SW'(cmd_src_addr) + SW'(cmd_len)) <= SW'(SRC_BYTES);
  assign dst_fits    = (SW'(cmd_dst_addr) + SW'(cmd_len)) <= SW'(DST_BYTES);
  assign last_write  = busy_q && wr_pend_q && (left_q == '0);

  assign busy         = busy_q;
  assign src_rd_en    = busy_q && (left_q != '0);
  assign src_rd_space = src_sp_q;
  assign src_rd_addr  = rd_addr_q;
  assign dst_wr_en    = wr_pend_q;
  assign dst_wr_space = dst_sp_q;
  assign dst_wr_addr  = wr_addr_q;
  assign dst_wr_data  = src_rd_data;
  assign res_valid    = res_valid_q;
  assign res_tag      = res_tag_q;
  assign res_value    = res_value_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      wr_pend_q   <= 1'b0;
      res_valid_q <= 1'b0;
      left_q      <= '0;
      rd_addr_q   <= '0;
      wr_addr_q   <= '0;
      src_sp_q    <= '0;
      dst_sp_q    <= '0;
      tag_q       <= '0;
      res_tag_q   <= '0;
      res_value_q <= '0;
    end else begin
      res_valid_q <= 1'b0;
      wr_pend_q   <= src_rd_en;
      if (src_rd_en) begin
        rd_addr_q <= rd_addr_q + 1'b1;
        left_q    <= left_q - 1'b1;
      end
      if (wr_pend_q) wr_addr_q <= wr_addr_q + 1'b1;
      if (last_write) begin
        busy_q      <= 1'b0;
        res_valid_q <= 1'b1;
        res_tag_q   <= tag_q;
        res_value_q <= RES_W'(dst_sp_q) + 1'b1;
      end
      if (accept) begin
        res_tag_q <= cmd_tag;
        if (!(src_fits && dst_fits)) begin
          res_valid_q <= 1'b1;
          res_value_q <= REJECT;
        end else if (cmd_len == '0) begin
          res_valid_q <= 1'b1;
          res_value_q <= RES_W'(cmd_dst_space) + 1'b1;
        end else begin
          busy_q    <= 1'b1;
          left_q    <= cmd_len;
          rd_addr_q <= cmd_src_addr;
          wr_addr_q <= cmd_dst_addr;
          src_sp_q  <= cmd_src_space;
          dst_sp_q  <= cmd_dst_space;
          tag_q     <= cmd_tag;
        end
      end
    end
  end
endmodule

// File: rtl/burst_copy_engine_props.sv
module burst_copy_engine_props #(
  parameter int SRC_BYTES = 64,
  parameter int DST_BYTES = 64,
  localparam int AW = $clog2(SRC_BYTES > DST_BYTES ? SRC_BYTES : DST_BYTES),
  localparam int LW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_kill,
  input logic          cmd_valid,
  input logic          cmd_refused,
  input logic          busy,
  input logic          src_rd_en,
  input logic [AW-1:0] src_rd_addr,
  input logic          dst_wr_en,
  input logic [AW-1:0] dst_wr_addr,
  input logic          res_valid
);
  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |=> dst_wr_en);
  assert_src_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |-> ({1'b0, src_rd_addr} < LW'(SRC_BYTES)));
  assert_dst_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> ({1'b0, dst_wr_addr} < LW'(DST_BYTES)));
  assert_write_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> busy);
  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_idle_on_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  assert_no_silent_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !res_valid) |=> (busy || res_valid));
  assert_kill_cmd_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && exec_kill && !busy && !res_valid) |=> !res_valid);
  assert_refuse_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |-> cmd_refused);
endmodule

bind burst_copy_engine burst_copy_engine_props #(
  .SRC_BYTES(SRC_BYTES), .DST_BYTES(DST_BYTES)
) u_props (
  .clk(clk), .rst_n(rst_n), .exec_kill(exec_kill), .cmd_valid(cmd_valid),
  .cmd_refused(cmd_refused), .busy(busy), .src_rd_en(src_rd_en),
  .src_rd_addr(src_rd_addr), .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr),
  .res_valid(res_valid)
);

// File: tb/burst_copy_engine_test.sv
module burst_copy_engine_test;
  localparam int SRC = 64, DST = 64, AW = 6, LW = 7;

  logic clk = 1'b0, rst_n = 1'b0, exec_kill = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_src_space = '0, cmd_dst_space = '0;
  logic [AW-1:0] cmd_src_addr = '0, cmd_dst_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [5:0] cmd_tag = '0;
  logic cmd_refused, busy, src_rd_en, dst_wr_en, res_valid;
  logic [2:0] src_rd_space, dst_wr_space;
  logic [AW-1:0] src_rd_addr, dst_wr_addr;
  logic [7:0] src_rd_data = '0, dst_wr_data, res_value;
  logic [5:0] res_tag;

  burst_copy_engine uut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] srcbyte(int sp, int a);
    return 8'((a * 7 + sp * 29 + 3) & 255);
  endfunction

  always @(posedge clk) if (src_rd_en) src_rd_data <= srcbyte(src_rd_space, src_rd_addr);

  logic [7:0] dmem [DST];
  int wr_count, res_count, last_space;
  logic clr = 1'b0;
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DST; i++) dmem[i] <= 8'hEE;
      wr_count <= 0; res_count <= 0;
    end else begin
      if (dst_wr_en) begin
        dmem[dst_wr_addr] <= dst_wr_data;
        wr_count <= wr_count + 1;
        last_space <= dst_wr_space;
      end
      if (res_valid) res_count <= res_count + 1;
    end
  end

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_dst();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic present(int ss, int sa, int len, int ds, int da, int tag, bit kill, output bit refused);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src_space = 3'(ss); cmd_src_addr = AW'(sa); cmd_len = LW'(len);
    cmd_dst_space = 3'(ds); cmd_dst_addr = AW'(da); cmd_tag = 6'(tag); exec_kill = kill;
    #1 refused = cmd_refused;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; exec_kill = 1'b0;
  endtask

  // mode 0 plain, 1 kill pulse mid-copy, 2 second command mid-copy
  task automatic wait_result(int mode, output int n, output bit got);
    n = 0; got = 0;
    while (n < 200) begin
      if (res_valid) begin got = 1; break; end
      if (n == 2 && mode == 1) exec_kill = 1'b1;
      if (n == 2 && mode == 2) begin
        cmd_valid = 1'b1; cmd_len = 7'd4; cmd_src_addr = 6'd0; cmd_dst_addr = 6'd0; cmd_tag = 6'd63;
        #1 check(cmd_refused == 1'b1, "R7", "refused while busy", int'(cmd_refused), 1);
      end
      if (n == 4) begin exec_kill = 1'b0; cmd_valid = 1'b0; end
      @(negedge clk); n++;
    end
    exec_kill = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic run_copy(int ss, int sa, int len, int ds, int da, int tag, int mode);
    bit refused, got, rej;
    int n, bad, exp_lat;
    string rq;
    rej = (sa + len > SRC) || (da + len > DST);
    rq = rej ? "R5" : (len == 0 ? "R4" : "R1");
    clear_dst();
    present(ss, sa, len, ds, da, tag, 1'b0, refused);
    check(refused == 1'b0, "R1", "accepted when idle", int'(refused), 0);
    wait_result(mode, n, got);
    exp_lat = (rej || len == 0) ? 0 : len + 1;
    check(got, rq, "result seen", int'(got), 1);
    check(n == exp_lat, rej ? "R5" : (len == 0 ? "R4" : (mode == 1 ? "R8" : "R2")), "latency", n, exp_lat);
    check(busy == 1'b0, "R10", "busy low in result cycle", int'(busy), 0);
    check(res_value == (rej ? 8'hFF : 8'(ds + 1)), rej ? "R5" : "R6", "result value", int'(res_value), rej ? 255 : ds + 1);
    check(res_tag == 6'(tag), "R6", "result tag", int'(res_tag), tag);
    @(negedge clk);
    check(res_valid == 1'b0, "R10", "result single pulse", int'(res_valid), 0);
    if (mode == 2) repeat (12) @(negedge clk);
    check(res_count == 1, mode == 2 ? "R7" : "R10", "result count", res_count, 1);
    check(wr_count == (rej ? 0 : len), rej ? "R5" : "R3", "write count", wr_count, rej ? 0 : len);
    if (!rej && len > 0) check(last_space == ds, "R1", "destination space", last_space, ds);
    bad = 0;
    for (int i = 0; i < DST; i++) begin
      logic [7:0] e;
      e = (!rej && i >= da && i < da + len) ? srcbyte(ss, sa + i - da) : 8'hEE;
      if (dmem[i] !== e) bad++;
    end
    check(bad == 0, mode == 1 ? "R8" : (rej ? "R5" : "R3"), "destination image mismatches", bad, 0);
  endtask

  initial begin
    bit refused, got;
    int n;
    repeat (3) @(negedge clk);
    check(!busy && !res_valid && !src_rd_en && !dst_wr_en, "R11", "reset outputs",
          int'({busy, res_valid, src_rd_en, dst_wr_en}), 0);
    rst_n = 1'b1;

    for (int len = 0; len <= 9; len++)
      for (int s = 0; s < 3; s++)
        for (int d = 0; d < 3; d++) begin
          int sa, da;
          sa = (s == 0) ? 0 : (s == 1 ? 5 : SRC - len);
          da = (d == 0) ? 0 : (d == 1 ? 3 : DST - len);
          run_copy((len + s) % 8, sa, len, (len + d) % 7, da, len * 3 + s + d, 0);
        end

    run_copy(2, 0, 64, 5, 0, 11, 0);   // R3 full buffer
    run_copy(1, 60, 5, 2, 0, 12, 0);   // R5 source overflow
    run_copy(1, 0, 5, 2, 61, 13, 0);   // R5 destination overflow
    run_copy(3, 1, 64, 0, 0, 14, 0);   // R5 full length, offset
    run_copy(4, 7, 10, 6, 20, 15, 1);  // R8 kill mid-copy
    run_copy(5, 2, 8, 1, 30, 16, 2);   // R7 second command while busy

    // R9 command coinciding with kill
    clear_dst();
    present(1, 0, 6, 1, 0, 20, 1'b1, refused);
    check(refused == 1'b1, "R9", "refused under kill", int'(refused), 1);
    repeat (12) @(negedge clk);
    check(res_count == 0, "R9", "no result under kill", res_count, 0);
    check(wr_count == 0, "R9", "no writes under kill", wr_count, 0);
    present(1, 0, 0, 1, 0, 21, 1'b0, refused);
    wait_result(0, n, got);
    check(got && n == 0, "R4", "zero count after kill", n, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule